// File: doc/BRIEF.md
# Clocked-Slave Serial Byte Port with Write-Collision Flag

This block is a byte-wide serial port on an 8-bit microcontroller's special-function-register bus. It works only as a slave. An external master drives the shift clock. The block takes in one data bit and drives out one data bit per clock period, most significant bit first. Software sees three registers: control, status and data. Writing the data register while the link is idle loads the next outgoing byte. Reading the data register returns the last complete byte that was received.

A write to the data register that arrives while a byte is in flight does not disturb the shift register. The new value is held and goes out with the following byte, and the write sets a collision flag. Both status flags clear with a two-step sequence: a status read that sees a flag set, followed by any data-register access. A system reset leaves the data register untouched. An external reset input, while held high, forces the port into slave receive mode, whatever the control register holds.

The same pins serve as a small general-purpose port. While the serial function is active it takes over three of them: data out, data in and shift clock. The shift clock and data input pass through two-flop synchronizers into the system clock domain before any edge is acted on.

Top module: `spi_port`

## Requirements
- R1: After system reset, control reads 0x04, status reads 0x00, and every pad output and pad output enable follows the general-purpose inputs.
- R2: System reset does not change the data register: the last received byte still reads back afterwards.
- R3: With the port enabled (control bit 6 = 1), the data input is sampled on each synchronized rising shift-clock edge, MSB first. After eight edges the byte reads back at the data address.
- R4: A byte written to the data register while idle appears on the data-out pad MSB first. Each bit advances on a falling shift-clock edge.
- R5: Status bit 7 (transfer done) sets on the eighth sampling edge of a byte.
- R6: A data write between the first and the eighth sampling edge sets status bit 6 (collision). It leaves the byte in flight unchanged, and the written value is sent as the next byte.
- R7: The flags clear only on a data-register access that follows a status read which saw a flag set. A data access without that status read leaves them set.
- R8: While the external reset input is high, the port receives as an enabled slave and never drives the data-out pad, even if control asks for it.
- R9: With the port disabled and the external reset input low, shift-clock edges are ignored and no flag sets.
- R10: When enabled, pad 0 carries serial data out, driven only if control bit 5 = 1. Pads 1 (data in) and 3 (shift clock) are not driven, and pads 2 and 4 follow the general-purpose inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| ext_rst | input | 1 | External reset, forces slave receive mode while high |
| addr | input | 8 | Register bus address |
| wdata | input | 8 | Register bus write data |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Register bus read data, valid while rd is high |
| pad_i | input | PW | Pad input levels |
| gpio_do | input | PW | General-purpose output values |
| gpio_oe | input | PW | General-purpose output enables |
| pad_o | output | PW | Pad output values |
| pad_oe | output | PW | Pad output enables |

## Verification
The bench builds the block with its default parameters. These give a five-pin port with data out on pad 0, data in on pad 1 and the shift clock on pad 3, plus the default register addresses. With these values the bench can check every pin-sharing case on real pads: pass-through pads, taken-over pads, and the output enable that the external reset suppresses. The shift clock runs slowly enough that synchronizer latency never hides an edge. This lets the bench place a collision write at a chosen bit, including writes that land mid-byte.

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port #(
  parameter int PW = 5,
  parameter int SDO_BIT = 0,
  parameter int SDI_BIT = 1,
  parameter int SCK_BIT = 3,
  parameter logic [7:0] A_CTRL = 8'hC4,
  parameter logic [7:0] A_STAT = 8'hC5,
  parameter logic [7:0] A_DATA = 8'hC6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rst,
  input  logic [7:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [7:0]    rdata,
  input  logic [PW-1:0] pad_i,
  input  logic [PW-1:0] gpio_do,
  input  logic [PW-1:0] gpio_oe,
  output logic [PW-1:0] pad_o,
  output logic [PW-1:0] pad_oe
);
  localparam logic [7:0] CTRL_RST = 8'h04;
  localparam int EN_BIT = 6;
  localparam int OE_BIT = 5;

  logic [7:0] ctrl, txbuf, rxbuf, tx_sh, rx_sh;
  logic [2:0] cnt, sck_s;
  logic [1:0] sdi_s;
  logic       done, wcol, seen, pend;

  wire en     = ctrl[EN_BIT] | ext_rst;
  wire drive  = ctrl[OE_BIT] & ~ext_rst;
  wire rise   = en & sck_s[1] & ~sck_s[2];
  wire fall   = en & ~sck_s[1] & sck_s[2];
  wire busy   = cnt != 3'd0;
  wire last   = rise && cnt == 3'd7;
  wire wr_d   = wr && addr == A_DATA;
  wire dacc   = (wr || rd) && addr == A_DATA;
  wire clr    = dacc && seen;
  wire [7:0] qnext = wr_d ? wdata : txbuf;

  logic unused_pins;
  assign unused_pins = ^pad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RST;
      cnt   <= '0;
      sck_s <= '0;
      sdi_s <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      done  <= 1'b0;
      wcol  <= 1'b0;
      seen  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], pad_i[SCK_BIT]};
      sdi_s <= {sdi_s[0], pad_i[SDI_BIT]};
      if (wr && addr == A_CTRL) ctrl <= wdata;
      if (!en) cnt <= '0;
      else if (rise) cnt <= cnt + 3'd1;
      if (rise) rx_sh <= {rx_sh[6:0], sdi_s[1]};
      if (wr_d && !busy) tx_sh <= wdata;
      else if (fall && busy) tx_sh <= {tx_sh[6:0], 1'b0};
      else if (last && (pend || wr_d)) tx_sh <= qnext;
      if (last) pend <= 1'b0;
      else if (wr_d && busy) pend <= 1'b1;
      if (last) done <= 1'b1;
      else if (clr) done <= 1'b0;
      if (wr_d && busy) wcol <= 1'b1;
      else if (clr) wcol <= 1'b0;
      if (rd && addr == A_STAT && (done || wcol)) seen <= 1'b1;
      else if (dacc) seen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_d) txbuf <= wdata;
    if (last) rxbuf <= {rx_sh[6:0], sdi_s[1]};
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == A_CTRL) rdata = ctrl;
      else if (addr == A_STAT) rdata = {done, wcol, 6'b0};
      else if (addr == A_DATA) rdata = rxbuf;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_pad
    if (i == SDO_BIT) begin : g_out
      assign pad_o[i]  = en ? tx_sh[7] : gpio_do[i];
      assign pad_oe[i] = en ? drive : gpio_oe[i];
    end else if (i == SDI_BIT || i == SCK_BIT) begin : g_in
      assign pad_o[i]  = gpio_do[i];
      assign pad_oe[i] = en ? 1'b0 : gpio_oe[i];
    end else begin : g_gp
      assign pad_o[i]  = gpio_do[i];
      assign pad_oe[i] = gpio_oe[i];
    end
  end

  a_r5_done_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  a_r6_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && busy) |=> wcol);
  a_r6_shift_reg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise && !fall) |=> $stable(tx_sh));
  a_r7_no_clear_unseen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !seen) |=> done);
  a_r8_no_drive_forced: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |-> !pad_oe[SDO_BIT] && !pad_oe[SCK_BIT] && !pad_oe[SDI_BIT]);
  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !done) |=> !done);
endmodule

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  localparam logic [7:0] A_CTRL = 8'hC4, A_STAT = 8'hC5, A_DATA = 8'hC6;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ext_rst = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic sck = 1'b0, sdi = 1'b0;
  logic [4:0] gpio_do = 5'b01100, gpio_oe = 5'b01010, pad_o, pad_oe, pad_i;
  assign pad_i = {1'b0, sck, 1'b0, sdi, 1'b0};

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  spi_port u_spi_port (.clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .pad_i(pad_i),
    .gpio_do(gpio_do), .gpio_oe(gpio_oe), .pad_o(pad_o), .pad_oe(pad_oe));

  localparam logic [15:0] VEC [6] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                      16'h81_7E, 16'h5B_C2, 16'h13_96};

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string r);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 chk(r, rdata, exp);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic xfer(logic [7:0] mo, int wat, logic [7:0] wd, output logic [7:0] so);
    for (int i = 7; i >= 0; i--) begin
      sdi = mo[i];
      repeat (6) @(negedge clk);
      so[i] = pad_o[0];
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
      repeat (6) @(negedge clk);
      if (i == wat) wr_reg(A_DATA, wd);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [7:0] so;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(A_CTRL, 8'h04, "R1 ctrl reset");
    rd_chk(A_STAT, 8'h00, "R1 stat reset");
    chk("R1 pad_oe follows gpio", {3'b0, pad_oe}, {3'b0, gpio_oe});
    chk("R10 pad_o disabled", {3'b0, pad_o}, {3'b0, gpio_do});
    xfer(8'hA5, -1, 8'h00, so);
    rd_chk(A_STAT, 8'h00, "R9 disabled no flag");

    wr_reg(A_CTRL, 8'h64);
    rd_chk(A_CTRL, 8'h64, "R10 ctrl write");
    chk("R10 pad_oe enabled", {3'b0, pad_oe}, 8'h01);
    chk("R10 gpio pads pass", {4'b0, pad_o[4:1]}, {4'b0, gpio_do[4:1]});

    for (int v = 0; v < 6; v++) begin
      wr_reg(A_DATA, VEC[v][7:0]);
      xfer(VEC[v][15:8], -1, 8'h00, so);
      chk("R4 sdo byte", so, VEC[v][7:0]);
      rd_chk(A_STAT, 8'h80, "R5 done set");
      rd_chk(A_DATA, VEC[v][15:8], "R3 rx byte");
      rd_chk(A_STAT, 8'h00, "R7 cleared");
    end

    wr_reg(A_DATA, 8'h3C);
    xfer(8'h81, 4, 8'hE7, so);
    chk("R6 byte in flight kept", so, 8'h3C);
    rd_chk(A_STAT, 8'hC0, "R6 wcol and done");
    rd_chk(A_DATA, 8'h81, "R3 rx after collision");
    rd_chk(A_STAT, 8'h00, "R7 both cleared");
    xfer(8'h42, -1, 8'h00, so);
    chk("R6 queued byte sent", so, 8'hE7);
    rd_chk(A_DATA, 8'h42, "R7 data read unseen");
    rd_chk(A_STAT, 8'h80, "R7 flag kept without status read");
    rd_chk(A_DATA, 8'h42, "R7 data read after status");
    rd_chk(A_STAT, 8'h00, "R7 flag cleared");

    xfer(8'h5A, -1, 8'h00, so);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_chk(A_DATA, 8'h5A, "R2 data survives reset");
    rd_chk(A_STAT, 8'h00, "R1 stat after reset");
    rd_chk(A_CTRL, 8'h04, "R1 ctrl after reset");

    gpio_oe = 5'b01011;
    wr_reg(A_CTRL, 8'h20);
    chk("R8 gpio oe before force", {7'b0, pad_oe[0]}, 8'h01);
    ext_rst = 1'b1;
    wr_reg(A_CTRL, 8'h60);
    chk("R8 sdo not driven", {7'b0, pad_oe[0]}, 8'h00);
    xfer(8'hC3, -1, 8'h00, so);
    rd_chk(A_STAT, 8'h80, "R8 forced receive done");
    rd_chk(A_DATA, 8'hC3, "R8 forced receive data");
    ext_rst = 1'b0;
    @(negedge clk);
    chk("R10 oe restored", {7'b0, pad_oe[0]}, 8'h01);
    finish_up();
  end
endmodule